// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block turns a single register write request into serial traffic for one or two display panels. The panel link has three lines: an active-low chip-select, a serial clock and a serial data line. A request carries an address byte, a data byte and a data-only flag. The block normally sends two 16-bit frames. The first is an index frame that holds the address. The second is a parameter frame that holds the data. Each frame sits inside its own chip-select window.

The serial clock idles high. The data line changes while the clock is low, and the panel samples it on the rising edge. Every phase of the link lasts one delay unit. The delay unit is the parameter `DELAY_CLKS`, counted in system clocks. When the dual mode input is set at request time, a second chip-select follows the main one exactly, so two panels receive the same frames. A one-cycle `done` pulse marks the end of the whole write.

Top module: `panel_reg_writer`

## Requirements
- R1: Every frame carries 16 bits, most significant bit first. Its upper byte is a prefix and its lower byte is the payload. The panel reads one bit on each rising edge of `sclk` while `cs_main_n` is low, so a frame has exactly 16 rising edges.
- R2: A normal write sends two frames in this order: first `{8'h70, addr}`, then `{8'h72, data}`.
- R3: When `req_addr` equals 8'hFF, or when `req_data_only` is 1, only the `{8'h72, data}` frame is sent.
- R4: While `busy` is 0, `cs_main_n`, `cs_sub_n`, `sclk` and `sdo` are all 1. This includes the state right after reset.
- R5: When chip-select falls, `sclk` and `sdo` are both high. Chip-select then stays low with `sclk` high for `DELAY_CLKS` clocks before the first clock fall.
- R6: Every low phase and every high phase of `sclk` inside a frame lasts `DELAY_CLKS` clocks. `sdo` does not change while `sclk` is high.
- R7: After the 16th rising edge, `sclk` stays high for `DELAY_CLKS` clocks and then chip-select rises. Chip-select then stays high for `DELAY_CLKS` clocks. In the next clock, `done` is 1 for exactly one cycle.
- R8: If `dual_en` is 1 when a request is accepted, `cs_sub_n` equals `cs_main_n` on every cycle of that write. Otherwise `cs_sub_n` stays 1.
- R9: A request that arrives while `busy` is 1 is ignored. It changes neither the frames in flight nor the number of frames sent.
- R10: Between two frames of one write, chip-select stays high for at least `DELAY_CLKS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe, taken when not busy |
| req_addr | input | 8 | Panel register address |
| req_data | input | 8 | Panel register value |
| req_data_only | input | 1 | Send the parameter frame only |
| dual_en | input | 1 | Drive the sub-panel chip-select as well |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse after the final frame |
| cs_main_n | output | 1 | Main panel chip-select, active low |
| cs_sub_n | output | 1 | Sub panel chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, idles high |

## Verification
The assertions check several line rules on every cycle:
- all lines rest high when the block is idle;
- `sclk` and `sdo` are high whenever chip-select is high;
- `sdo` holds steady through every clock-high phase;
- the sub chip-select matches the main one in dual mode;
- `done` never lasts two cycles;
- a frame start never reaches a busy serializer.

Other behaviour can only be shown by the bench scenarios, which decode the link from the pins. These include the frame contents and their order, the prefix choice, and the skipped index frame for both data-only triggers. They also include the exact phase lengths, the gap from chip-select release to `done`, and that a request made mid-write is dropped.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  localparam logic [BYTE_W-1:0] PFX_INDEX      = 8'h70;
  localparam logic [BYTE_W-1:0] PFX_PARAM      = 8'h72;
  localparam logic [BYTE_W-1:0] ADDR_DATA_ONLY = 8'hFF;

  typedef enum logic [2:0] {
    SER_IDLE, SER_PRE, SER_LEAD, SER_BLO, SER_BHI, SER_TAIL
  } ser_state_t;

  typedef enum logic [1:0] {
    SEQ_IDLE, SEQ_INDEX, SEQ_PARAM
  } seq_state_t;
endpackage

// File: rtl/pw_frame_builder.sv
module pw_frame_builder
  import pw_pkg::*;
(
  input  logic [BYTE_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  data,
  input  logic               data_only,
  output logic [FRAME_W-1:0] index_word,
  output logic [FRAME_W-1:0] param_word,
  output logic               skip_index
);
  always_comb begin
    index_word = {PFX_INDEX, addr};
    param_word = {PFX_PARAM, data};
    skip_index = data_only || (addr == ADDR_DATA_ONLY);
  end
endmodule

// File: rtl/pw_bit_serializer.sv
module pw_bit_serializer
  import pw_pkg::*;
#(
  parameter int unsigned DELAY_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  input  logic               dual,
  output logic               frame_done,
  output logic               cs_main_n,
  output logic               cs_sub_n,
  output logic               sclk,
  output logic               sdo
);
  localparam int unsigned CNT_W = (DELAY_CLKS > 1) ? $clog2(DELAY_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CLKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  ser_state_t         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               dual_q, dual_d;
  logic               cs_q, cs_d, csb_q, csb_d, sclk_q, sclk_d, sdo_q, sdo_d;
  logic               cnt_zero, cnt_en;

  assign cnt_zero   = (cnt_q == '0);
  assign cnt_en     = (st_q != SER_IDLE);
  assign frame_done = (st_q == SER_TAIL) && cnt_zero;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    dual_d = dual_q;
    cnt_d  = cnt_zero ? CNT_LOAD : cnt_q - 1'b1;
    unique case (st_q)
      SER_IDLE: begin
        cnt_d = CNT_LOAD;
        if (start) begin
          st_d   = SER_PRE;
          sh_d   = word;
          dual_d = dual;
        end
      end
      SER_PRE:  if (cnt_zero) st_d = SER_LEAD;
      SER_LEAD: if (cnt_zero) begin
        st_d  = SER_BLO;
        bit_d = BIT_LAST;
      end
      SER_BLO:  if (cnt_zero) st_d = SER_BHI;
      SER_BHI:  if (cnt_zero) begin
        if (bit_q == '0) begin
          st_d = SER_TAIL;
        end else begin
          st_d  = SER_BLO;
          bit_d = bit_q - 1'b1;
          sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
        end
      end
      SER_TAIL: if (cnt_zero) st_d = SER_IDLE;
      default:  st_d = SER_IDLE;
    endcase
    // line levels follow the state being entered
    cs_d   = !((st_d == SER_LEAD) || (st_d == SER_BLO) || (st_d == SER_BHI));
    csb_d  = dual_d ? cs_d : 1'b1;
    sclk_d = (st_d != SER_BLO);
    sdo_d  = ((st_d == SER_BLO) || (st_d == SER_BHI)) ? sh_d[FRAME_W-1] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      dual_q <= 1'b0;
      cs_q   <= 1'b1;
      csb_q  <= 1'b1;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      dual_q <= dual_d;
      cs_q   <= cs_d;
      csb_q  <= csb_d;
      sclk_q <= sclk_d;
      sdo_q  <= sdo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
    else             cnt_q <= CNT_LOAD;
  end

  assign cs_main_n = cs_q;
  assign cs_sub_n  = csb_q;
  assign sclk      = sclk_q;
  assign sdo       = sdo_q;

  // R10: a new frame is only launched into an idle serializer
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == SER_IDLE));
  // R5: clock and data are high whenever chip-select is released
  p_cs_high_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> (sclk_q && sdo_q));
  // R6: data holds through a clock-high phase
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && sclk_q && $past(sclk_q) && !$past(cs_q)) |-> $stable(sdo_q));
  // R8: sub chip-select tracks main in dual mode
  p_sub_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dual_q |-> (csb_q == cs_q));
endmodule

// File: rtl/pw_write_sequencer.sv
module pw_write_sequencer
  import pw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FRAME_W-1:0] index_word,
  input  logic [FRAME_W-1:0] param_word,
  input  logic               skip_index,
  input  logic               dual_en,
  input  logic               frame_done,
  output logic               start,
  output logic [FRAME_W-1:0] word,
  output logic               dual,
  output logic               busy,
  output logic               done
);
  seq_state_t         st_q, st_d;
  logic [FRAME_W-1:0] par_q, par_d, word_q, word_d;
  logic               dual_q, dual_d, start_q, start_d, done_q, done_d;

  always_comb begin
    st_d    = st_q;
    par_d   = par_q;
    word_d  = word_q;
    dual_d  = dual_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (req_valid) begin
        par_d   = param_word;
        dual_d  = dual_en;
        start_d = 1'b1;
        word_d  = skip_index ? param_word : index_word;
        st_d    = skip_index ? SEQ_PARAM : SEQ_INDEX;
      end
      SEQ_INDEX: if (frame_done) begin
        start_d = 1'b1;
        word_d  = par_q;
        st_d    = SEQ_PARAM;
      end
      SEQ_PARAM: if (frame_done) begin
        done_d = 1'b1;
        st_d   = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      par_q   <= '0;
      word_q  <= '0;
      dual_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      par_q   <= par_d;
      word_q  <= word_d;
      dual_q  <= dual_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign start = start_q;
  assign word  = word_q;
  assign dual  = dual_q;
  assign busy  = (st_q != SEQ_IDLE);
  assign done  = done_q;

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: a latched write is not disturbed by later requests
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SEQ_IDLE) |=> ($stable(par_q) && $stable(dual_q)));
endmodule

// File: rtl/panel_reg_writer.sv
module panel_reg_writer
  import pw_pkg::*;
#(
  parameter int unsigned DELAY_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       req_data_only,
  input  logic       dual_en,
  output logic       busy,
  output logic       done,
  output logic       cs_main_n,
  output logic       cs_sub_n,
  output logic       sclk,
  output logic       sdo
);
  logic [FRAME_W-1:0] index_word, param_word, ser_word;
  logic               skip_index, ser_start, ser_dual, frame_done;

  pw_frame_builder u_build (
    .addr       (req_addr),
    .data       (req_data),
    .data_only  (req_data_only),
    .index_word (index_word),
    .param_word (param_word),
    .skip_index (skip_index)
  );

  pw_write_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .index_word (index_word),
    .param_word (param_word),
    .skip_index (skip_index),
    .dual_en    (dual_en),
    .frame_done (frame_done),
    .start      (ser_start),
    .word       (ser_word),
    .dual       (ser_dual),
    .busy       (busy),
    .done       (done)
  );

  pw_bit_serializer #(.DELAY_CLKS(DELAY_CLKS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ser_start),
    .word       (ser_word),
    .dual       (ser_dual),
    .frame_done (frame_done),
    .cs_main_n  (cs_main_n),
    .cs_sub_n   (cs_sub_n),
    .sclk       (sclk),
    .sdo        (sdo)
  );

  // R4: all link lines rest high while idle
  p_idle_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_main_n && cs_sub_n && sclk && sdo));
endmodule

// File: tb/tb_panel_reg_writer.sv
`timescale 1ns/1ps
module tb_panel_reg_writer;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_data_only = 1'b0, dual_en = 1'b0;
  logic [7:0] req_addr = 8'h00, req_data = 8'h00;
  logic busy, done, cs_main_n, cs_sub_n, sclk, sdo;

  panel_reg_writer #(.DELAY_CLKS(D)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_data_only(req_data_only), .dual_en(dual_en),
    .busy(busy), .done(done), .cs_main_n(cs_main_n), .cs_sub_n(cs_sub_n),
    .sclk(sclk), .sdo(sdo));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // link monitor
  logic mon_rst = 1'b0, exp_dual = 1'b0;
  logic [15:0] frames [0:3];
  int fbits [0:3];
  int nfr, tim_err, sdo_err, sub_err, gap_err, done_cnt, done_gap, done_nfr;
  int run, hi_run, bits;
  bit first;
  logic [15:0] shreg;
  logic p_cs, p_sclk, p_sdo;

  always @(negedge clk) begin
    if (mon_rst) begin
      nfr = 0; tim_err = 0; sdo_err = 0; sub_err = 0; gap_err = 0;
      done_cnt = 0; done_gap = 0; done_nfr = 0; run = 0; hi_run = 0;
      bits = 0; first = 1'b1; shreg = '0;
      for (int i = 0; i < 4; i++) begin frames[i] = '0; fbits[i] = 0; end
    end else begin
      if (exp_dual ? (cs_sub_n !== cs_main_n) : (cs_sub_n !== 1'b1)) sub_err++;
      if (p_cs && !cs_main_n) begin
        if (!(sclk && sdo)) tim_err++;
        if (!first && hi_run < D) gap_err++;
        first = 1'b0; run = 1; bits = 0; shreg = '0;
      end else if (!cs_main_n) begin
        if (sclk == p_sclk) run++;
        else begin
          if (run != D) tim_err++;
          run = 1;
        end
        if (sclk && !p_sclk) begin shreg = {shreg[14:0], sdo}; bits++; end
        if (sclk && p_sclk && sdo !== p_sdo) sdo_err++;
      end else if (!p_cs && cs_main_n) begin
        if (run != D) tim_err++;
        if (nfr < 4) begin frames[nfr] = shreg; fbits[nfr] = bits; end
        nfr++; hi_run = 1;
      end else hi_run++;
      if (done) begin done_cnt++; done_gap = hi_run; done_nfr = nfr; end
    end
    p_cs = cs_main_n; p_sclk = sclk; p_sdo = sdo;
  end

  task automatic clear_mon(input logic dual);
    @(negedge clk); #1; exp_dual = dual; mon_rst = 1'b1;
    @(negedge clk); #1; mon_rst = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] a, input logic [7:0] d, input logic f, input logic du);
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_data = d; req_data_only = f; dual_en = du;
    @(negedge clk); #1;
    req_valid = 1'b0; req_addr = 8'h5A; req_data = 8'hA5; req_data_only = 1'b0; dual_en = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
    chk(done_cnt != 0, {tag, " R7 done seen"}, done_cnt, 1);
    repeat (2 * D + 6) @(negedge clk);
  endtask

  task automatic check_write(input logic [7:0] a, input logic [7:0] d, input logic f,
                             input logic du, input string tag);
    bit skip = f || (a == 8'hFF);
    int en = skip ? 1 : 2;
    logic [15:0] w0 = skip ? {8'h72, d} : {8'h70, a};
    chk(nfr == en, {tag, " R3 frame count"}, nfr, en);
    chk(frames[0] == w0, {tag, " R2 first frame"}, frames[0], w0);
    if (!skip) chk(frames[1] == {8'h72, d}, {tag, " R2 second frame"}, frames[1], {8'h72, d});
    chk(fbits[0] == 16 && fbits[en-1] == 16, {tag, " R1 bits per frame"}, fbits[0], 16);
    chk(tim_err == 0, {tag, " R5 R6 phase timing"}, tim_err, 0);
    chk(sdo_err == 0, {tag, " R6 data stable on high clock"}, sdo_err, 0);
    chk(gap_err == 0, {tag, " R10 inter-frame gap"}, gap_err, 0);
    chk(done_cnt == 1, {tag, " R7 done width"}, done_cnt, 1);
    chk(done_gap == D + 1 && done_nfr == en, {tag, " R7 done timing"}, done_gap, D + 1);
    chk(sub_err == 0, {tag, " R8 sub chip-select"}, sub_err, 0);
    chk(!busy && cs_main_n && cs_sub_n && sclk && sdo, {tag, " R4 idle after write"},
        {busy, cs_main_n, cs_sub_n, sclk, sdo}, 5'b01111);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [7:0] d, input logic f,
                         input logic du, input string tag);
    clear_mon(du);
    pulse_req(a, d, f, du);
    wait_done(tag);
    check_write(a, d, f, du, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_main_n && cs_sub_n && sclk && sdo, "R4 lines in reset",
        {cs_main_n, cs_sub_n, sclk, sdo}, 4'hF);
    chk(!busy && !done, "R4 busy/done in reset", {busy, done}, 0);
    @(negedge clk); #1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_main_n && cs_sub_n && sclk && sdo && !busy, "R4 idle after reset",
        {cs_main_n, cs_sub_n, sclk, sdo, busy}, 5'b11110);
  endtask

  task automatic t_busy_ignore;
    clear_mon(1'b0);
    pulse_req(8'h31, 8'h08, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1, "R9 busy mid write", busy, 1);
    pulse_req(8'hFF, 8'hC3, 1'b1, 1'b1);
    wait_done("busy-ignore");
    repeat (200) @(negedge clk);
    check_write(8'h31, 8'h08, 1'b0, 1'b0, "busy-ignore R9");
  endtask

  initial begin
    t_reset();
    t_write(8'h31, 8'h08, 1'b0, 1'b0, "plain");
    t_write(8'hEF, 8'hD0, 1'b0, 1'b1, "dual");
    t_write(8'hFF, 8'hE8, 1'b0, 1'b0, "addr data-only");
    t_write(8'h14, 8'h03, 1'b1, 1'b1, "flag data-only");
    t_write(8'h00, 8'hFF, 1'b0, 1'b0, "zero addr ones data");
    t_write(8'hAA, 8'h55, 1'b0, 1'b1, "alternating");
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule